// File: doc/BRIEF.md
# Hex-Radix Floating Shift-Add Multiplier

This block multiplies two floating operands held in base-16, excess-64 form. A word carries a sign bit, a 7-bit biased exponent, and a 24-bit fraction made of six hex digits. A second word extends the fraction by 32 bits for double precision. The block is sequential. On `start` it latches both operands and checks for a zero fraction. It then forms the exponent sum and tests that sum against the representable range. If neither check ends the operation, the fraction product is built by shift-and-add at one iteration per clock. After the product is normalized, it is rounded in single precision or truncated in double precision, then packed.

The caller presents both operands already normalized, with a nonzero leading hex digit unless the operand is zero. After reset the caller pulses `start` and waits for `done`. The packed result words and the condition code stay valid from `done` until the next result.

Top module: `hfm_mul`

## Requirements
- R1: After reset `res_hi`, `res_lo` and `cc` are all zero and `done` is low.
- R2: If either operand fraction is zero, the result is `res_hi = 0`, `res_lo = 0`, `cc = 3'b000`, whatever the signs and exponents are. The result appears one clock edge after the edge that accepts `start`. The sign of a zero is cleared.
- R3: `cc` uses bit 2 for V, bit 1 for G and bit 0 for L. The result sign is the XOR of the operand signs. The result exponent starts as e1 + e2 - 64. A normal positive result gives `cc = 3'b010` and a normal negative result gives `3'b001`. Result fields: bit 31 is the sign, bits 30:24 the exponent, bits 23:0 the fraction.
- R4: The range test runs on e1 + e2 - 64 before any normalization. A sum above 127 overflows and a sum below 0 underflows, and either ends the operation one edge after acceptance. A sum of 128 overflows even when normalization would lower it. A sum of 127 that needs one digit shift yields exponent 126.
- R5: An overflow result is `res_hi` = the sign bit followed by 31 ones, `res_lo` = all ones, with `cc` = V plus G (positive) or V plus L (negative).
- R6: An underflow result is `res_hi = 0`, `res_lo = 0`, `cc = 3'b100`.
- R7: The product fraction is formed as follows, with F1 = {hi fraction, lo word} of the multiplicand:
  - In double precision with a nonzero multiplier low word, the product is floor(F1 × F2 / 2^56) over 56 iterations, with F2 as the full 56-bit multiplier fraction.
  - Otherwise it is floor(F1 × F2hi / 2^24) over 24 iterations.
  - In single precision both low words are ignored.
- R8: In the iterative path, `done` rises N + 2 edges after the accepting edge. N is the iteration count from R7. Each normalization digit shift adds one more edge.
- R9: The product is shifted left one hex digit at a time, decrementing the exponent, until its leading digit is nonzero. An exponent below 0 at that point gives the underflow result, even if rounding would have raised it.
- R10: Single precision adds 1 to the 24-bit fraction when bit 31 of the low product word is set. A carry out of the fraction sets it to 0x100000 and raises the exponent by 1. Single-precision non-overflow results have `res_lo = 0`.
- R11: Double precision truncates: `res_lo` is the low 32 product fraction bits after normalization, with no rounding.
- R12: `start` is ignored while an operation is in progress, and operands are latched at acceptance.
- R13: `done` is high for exactly one cycle per result, and the outputs hold their value afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a multiply (accepted only when idle) |
| dbl_prec | input | 1 | 1 selects 56-bit fractions, 0 selects 24-bit |
| a_hi | input | 32 | Multiplicand: sign, exponent, high fraction |
| a_lo | input | 32 | Multiplicand low fraction word (double only) |
| b_hi | input | 32 | Multiplier: sign, exponent, high fraction |
| b_lo | input | 32 | Multiplier low fraction word (double only) |
| res_hi | output | 32 | Packed result high word |
| res_lo | output | 32 | Result low fraction word |
| cc | output | 3 | Condition code {V, G, L} |
| done | output | 1 | One-cycle result strobe |

## Verification
The normalization check relies on both inputs being normalized. Under that condition a nonzero product fraction needs at most one digit shift, so every non-exception result has a nonzero leading digit. The overflow and underflow shape checks assume that exponent range errors arise only from the exponent sum or the post-normalization test. Every stimulus word in the bench is therefore either zero or has a nonzero leading hex digit. `start` is raised only while the block is idle, except in the one test that deliberately pulses it mid-operation.

// File: rtl/hfm_pkg.sv
package hfm_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_MUL, ST_NORM, ST_FIN} hfm_state_e;
   localparam int CC_W = 3;
   localparam int CC_V = 2;
   localparam int CC_G = 1;
   localparam int CC_L = 0;
endpackage

// File: rtl/hfm_prescreen.sv
module hfm_prescreen #(
   parameter int WORD_W = 32,
   parameter int EXP_W  = 7,
   localparam int HI_FRAC_W = WORD_W - 1 - EXP_W,
   localparam int FRAC_W    = HI_FRAC_W + WORD_W,
   localparam int ESUM_W    = EXP_W + 3,
   localparam int CNT_W     = $clog2(FRAC_W + 1)
) (
   input  logic                     dbl_prec,
   input  logic [WORD_W-1:0]        a_hi,
   input  logic [WORD_W-1:0]        a_lo,
   input  logic [WORD_W-1:0]        b_hi,
   input  logic [WORD_W-1:0]        b_lo,
   output logic                     is_zero,
   output logic                     sign,
   output logic signed [ESUM_W-1:0] exp_sum,
   output logic                     range_exc,
   output logic [FRAC_W-1:0]        mcand,
   output logic [FRAC_W-1:0]        mplier,
   output logic [CNT_W-1:0]         iters
);
   localparam int BIAS    = 1 << (EXP_W - 1);
   localparam int EXP_MAX = (1 << EXP_W) - 1;
   localparam logic signed [ESUM_W-1:0] EXP_MAX_S = ESUM_W'(EXP_MAX);

   logic [HI_FRAC_W-1:0] fa_h, fb_h;
   logic [WORD_W-1:0]    fa_l, fb_l;
   logic                 long_run;

   assign fa_h = a_hi[HI_FRAC_W-1:0];
   assign fb_h = b_hi[HI_FRAC_W-1:0];
   assign fa_l = dbl_prec ? a_lo : '0;
   assign fb_l = dbl_prec ? b_lo : '0;

   assign mcand    = {fa_h, fa_l};
   assign is_zero  = (mcand == '0) || ({fb_h, fb_l} == '0);
   assign sign     = a_hi[WORD_W-1] ^ b_hi[WORD_W-1];
   assign exp_sum  = ESUM_W'(a_hi[WORD_W-2 -: EXP_W]) + ESUM_W'(b_hi[WORD_W-2 -: EXP_W])
                   - ESUM_W'(BIAS);
   assign range_exc = (exp_sum < 0) || (exp_sum > EXP_MAX_S);

   // multiplier low word decides the iteration count
   assign long_run = (fb_l != '0);
   assign mplier   = long_run ? {fb_h, fb_l} : FRAC_W'(fb_h);
   assign iters    = long_run ? CNT_W'(FRAC_W) : CNT_W'(HI_FRAC_W);
endmodule

// File: rtl/hfm_shift_add.sv
module hfm_shift_add #(
   parameter int FRAC_W = 56
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [FRAC_W-1:0] mcand_in,
   input  logic [FRAC_W-1:0] mplier_in,
   input  logic [FRAC_W-1:0] acc_init,
   input  logic              step,
   input  logic              nrm,
   output logic [FRAC_W-1:0] acc
);
   logic [FRAC_W-1:0] mcand_q, mplier_q;
   logic [FRAC_W:0]   sum;

   assign sum = {1'b0, acc} + (mplier_q[0] ? {1'b0, mcand_q} : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q  <= '0;
         mplier_q <= '0;
         acc      <= '0;
      end else if (load) begin
         mcand_q  <= mcand_in;
         mplier_q <= mplier_in;
         acc      <= acc_init;
      end else if (step) begin
         acc      <= sum[FRAC_W:1];
         mplier_q <= mplier_q >> 1;
      end else if (nrm) begin
         acc      <= {acc[FRAC_W-5:0], 4'h0};
      end
   end
endmodule

// File: rtl/hfm_packer.sv
module hfm_packer #(
   parameter int WORD_W  = 32,
   parameter int EXP_W   = 7,
   parameter bit RND_SGL = 1'b1,
   localparam int HI_FRAC_W = WORD_W - 1 - EXP_W,
   localparam int FRAC_W    = HI_FRAC_W + WORD_W,
   localparam int ESUM_W    = EXP_W + 3
) (
   input  logic                     dbl_prec,
   input  logic                     sign,
   input  logic signed [ESUM_W-1:0] exp_in,
   input  logic [FRAC_W-1:0]        frac,
   output logic [WORD_W-1:0]        hi,
   output logic [WORD_W-1:0]        lo,
   output logic [2:0]               cc
);
   import hfm_pkg::*;
   localparam logic signed [ESUM_W-1:0] EXP_MAX_S = ESUM_W'((1 << EXP_W) - 1);

   logic [HI_FRAC_W-1:0]     h_r;
   logic signed [ESUM_W-1:0] e_r;
   logic                     uflow_pre;

   assign uflow_pre = (exp_in < 0) && (frac != '0);

   generate
      if (RND_SGL) begin : g_round
         logic [HI_FRAC_W:0] s;
         assign s   = {1'b0, frac[FRAC_W-1:WORD_W]}
                    + (HI_FRAC_W+1)'(!dbl_prec && frac[WORD_W-1]);
         assign h_r = s[HI_FRAC_W] ? HI_FRAC_W'(s >> 4) : s[HI_FRAC_W-1:0];
         assign e_r = s[HI_FRAC_W] ? exp_in + ESUM_W'(1) : exp_in;
      end else begin : g_trunc
         assign h_r = frac[FRAC_W-1:WORD_W];
         assign e_r = exp_in;
      end
   endgenerate

   always_comb begin
      hi = {sign, e_r[EXP_W-1:0], h_r};
      lo = dbl_prec ? frac[WORD_W-1:0] : '0;
      cc = '0;
      cc[sign ? CC_L : CC_G] = 1'b1;
      if (uflow_pre) begin
         hi = '0;
         lo = '0;
         cc = '0;
         cc[CC_V] = 1'b1;
      end else if (h_r == '0) begin
         hi = '0;
         lo = '0;
         cc = '0;
      end else if (e_r > EXP_MAX_S) begin
         hi = {sign, {(WORD_W-1){1'b1}}};
         lo = '1;
         cc[CC_V] = 1'b1;
      end
   end
endmodule

// File: rtl/hfm_mul.sv
module hfm_mul #(
   parameter int WORD_W  = 32,
   parameter int EXP_W   = 7,
   parameter bit RND_SGL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              dbl_prec,
   input  logic [WORD_W-1:0] a_hi,
   input  logic [WORD_W-1:0] a_lo,
   input  logic [WORD_W-1:0] b_hi,
   input  logic [WORD_W-1:0] b_lo,
   output logic [WORD_W-1:0] res_hi,
   output logic [WORD_W-1:0] res_lo,
   output logic [2:0]        cc,
   output logic              done
);
   import hfm_pkg::*;
   localparam int HI_FRAC_W = WORD_W - 1 - EXP_W;
   localparam int FRAC_W    = HI_FRAC_W + WORD_W;
   localparam int ESUM_W    = EXP_W + 3;
   localparam int CNT_W     = $clog2(FRAC_W + 1);
   localparam logic [FRAC_W-1:0] EXC_FRAC = FRAC_W'(1) << (FRAC_W - 4);

   generate
      if (HI_FRAC_W % 4 != 0) begin : g_bad_digits
         $error("high fraction must be whole hex digits");
      end
      if (EXP_W < 2 || HI_FRAC_W < 8) begin : g_bad_fields
         $error("exponent or fraction field too narrow");
      end
   endgenerate

   hfm_state_e state;
   logic [CNT_W-1:0]         cnt;
   logic                     sign_q, dbl_q;
   logic signed [ESUM_W-1:0] exp_q;

   logic                     is_zero, sign_c, range_exc;
   logic signed [ESUM_W-1:0] exp_sum;
   logic [FRAC_W-1:0]        mcand, mplier, acc, acc_init;
   logic [CNT_W-1:0]         iters;
   logic                     load, step, nrm, lead_zero;
   logic [WORD_W-1:0]        pk_hi, pk_lo;
   logic [2:0]               pk_cc;

   hfm_prescreen #(.WORD_W(WORD_W), .EXP_W(EXP_W)) u_pre (
      .dbl_prec(dbl_prec), .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
      .is_zero(is_zero), .sign(sign_c), .exp_sum(exp_sum), .range_exc(range_exc),
      .mcand(mcand), .mplier(mplier), .iters(iters));

   assign load      = (state == ST_IDLE) && start;
   assign step      = (state == ST_MUL);
   assign lead_zero = (acc[FRAC_W-1 -: 4] == 4'h0) && (acc != '0);
   assign nrm       = (state == ST_NORM) && lead_zero;
   assign acc_init  = is_zero ? '0 : (range_exc ? EXC_FRAC : '0);

   hfm_shift_add #(.FRAC_W(FRAC_W)) u_sa (
      .clk(clk), .rst_n(rst_n), .load(load), .mcand_in(mcand), .mplier_in(mplier),
      .acc_init(acc_init), .step(step), .nrm(nrm), .acc(acc));

   hfm_packer #(.WORD_W(WORD_W), .EXP_W(EXP_W), .RND_SGL(RND_SGL)) u_pack (
      .dbl_prec(dbl_q), .sign(sign_q), .exp_in(exp_q), .frac(acc),
      .hi(pk_hi), .lo(pk_lo), .cc(pk_cc));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         sign_q <= 1'b0;
         dbl_q  <= 1'b0;
         exp_q  <= '0;
         res_hi <= '0;
         res_lo <= '0;
         cc     <= '0;
         done   <= 1'b0;
      end else begin
         done <= (state == ST_FIN);
         unique case (state)
            ST_IDLE: if (start) begin
               dbl_q  <= dbl_prec;
               sign_q <= sign_c;
               exp_q  <= is_zero ? '0 : exp_sum;
               cnt    <= iters;
               state  <= (is_zero || range_exc) ? ST_FIN : ST_MUL;
            end
            ST_MUL: begin
               cnt <= cnt - CNT_W'(1);
               if (cnt == CNT_W'(1)) state <= ST_NORM;
            end
            ST_NORM: begin
               if (lead_zero) exp_q <= exp_q - ESUM_W'(1);
               else           state <= ST_FIN;
            end
            ST_FIN: begin
               res_hi <= pk_hi;
               res_lo <= pk_lo;
               cc     <= pk_cc;
               state  <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_zero_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cc == 3'b000) |-> (res_hi == '0 && res_lo == '0));
   assert_sign_cc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $onehot0(cc[1:0]));
   assert_early_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start && range_exc) |=> (state == ST_FIN));
   assert_ovf_form_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cc[CC_V] && cc[1:0] != 2'b00) |->
      (res_hi[WORD_W-2:0] == '1 && res_lo == '1 && res_hi[WORD_W-1] == cc[CC_L]));
   assert_uflow_form_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cc == 3'b100) |-> (res_hi == '0 && res_lo == '0));
   assert_norm_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !cc[CC_V] && cc[1:0] != 2'b00) |-> (res_hi[HI_FRAC_W-1 -: 4] != 4'h0));
   assert_sgl_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !dbl_q && !cc[CC_V]) |-> (res_lo == '0));
   assert_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MUL && start) |=> (state != ST_IDLE && $stable(dbl_q)));
endmodule

// File: tb/hfm_mul_tb.sv
module hfm_mul_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 15;
   // {dbl, a_hi, a_lo, b_hi, b_lo, expected cc}
   localparam logic [131:0] VEC [NVEC] = '{
      {1'b0, 32'h41100000, 32'h0,        32'h41100000, 32'h0,        3'b010},
      {1'b0, 32'h41200000, 32'h0,        32'hC1300000, 32'h0,        3'b001},
      {1'b0, 32'h413FFFFF, 32'h0,        32'h41400001, 32'h0,        3'b010},
      {1'b0, 32'h40FFFFFF, 32'hDEADBEEF, 32'h40FFFFFF, 32'h12345678, 3'b010},
      {1'b1, 32'h41FFFFFF, 32'hFFFFFFFF, 32'h41FFFFFF, 32'hFFFFFFFF, 3'b010},
      {1'b1, 32'hC1100000, 32'h00000001, 32'h41200000, 32'h0,        3'b001},
      {1'b0, 32'h7F100000, 32'h0,        32'h7F100000, 32'h0,        3'b110},
      {1'b0, 32'hFF100000, 32'h0,        32'h41100000, 32'h0,        3'b101},
      {1'b0, 32'h01100000, 32'h0,        32'h01100000, 32'h0,        3'b100},
      {1'b0, 32'h20100000, 32'h0,        32'h20100000, 32'h0,        3'b100},
      {1'b0, 32'h7F100000, 32'h0,        32'h40100000, 32'h0,        3'b010},
      {1'b0, 32'h80000000, 32'h0,        32'hC1200000, 32'h0,        3'b000},
      {1'b1, 32'h41200000, 32'h0,        32'h00000000, 32'h0,        3'b000},
      {1'b1, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h40FFFFFF, 32'h00000001, 3'b010},
      {1'b0, 32'h20800000, 32'h0,        32'h20200000, 32'h0,        3'b010}
   };

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dbl_prec = 1'b0;
   logic [31:0] a_hi = '0, a_lo = '0, b_hi = '0, b_lo = '0;
   logic [31:0] res_hi, res_lo;
   logic [2:0]  cc;
   logic        done;
   int n_chk = 0, n_err = 0, got_cnt = 0;
   bit finished = 1'b0;
   logic [31:0] got_hi, got_lo;
   logic [2:0]  got_cc;
   string vtag [NVEC];

   always #(CLK_PERIOD/2) clk = ~clk;

   hfm_mul u_dut (.clk(clk), .rst_n(rst_n), .start(start), .dbl_prec(dbl_prec),
      .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
      .res_hi(res_hi), .res_lo(res_lo), .cc(cc), .done(done));

   task automatic chk(input string req, input string what, input logic [63:0] act, exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [66:0] model(input logic dbl, input logic [31:0] ahi, alo, bhi, blo);
      logic s;
      int e;
      logic [55:0] f1, f2, q;
      logic [111:0] p;
      logic [24:0] h;
      logic [31:0] lo;
      s  = ahi[31] ^ bhi[31];
      f1 = {ahi[23:0], dbl ? alo : 32'h0};
      f2 = {bhi[23:0], dbl ? blo : 32'h0};
      if (f1 == '0 || f2 == '0) return '0;
      e = int'(ahi[30:24]) + int'(bhi[30:24]) - 64;
      if (e < 0) return {3'b100, 64'h0};
      if (e > 127) return {s ? 3'b101 : 3'b110, s ? 32'hFFFFFFFF : 32'h7FFFFFFF, 32'hFFFFFFFF};
      if (f2[31:0] != 0) begin
         p = {56'h0, f1} * {56'h0, f2};
         q = p[111:56];
      end else begin
         p = {56'h0, f1} * {88'h0, f2[55:32]};
         q = p[79:24];
      end
      for (int i = 0; i < 14; i++)
         if (q[55:52] == 4'h0 && q != '0) begin q = q << 4; e--; end
      if (e < 0) return {3'b100, 64'h0};
      lo = dbl ? q[31:0] : 32'h0;
      h  = {1'b0, q[55:32]};
      if (!dbl && q[31]) begin
         h = h + 25'd1;
         if (h[24]) begin h = h >> 4; e++; end
      end
      if (h == '0) return '0;
      if (e > 127) return {s ? 3'b101 : 3'b110, s ? 32'hFFFFFFFF : 32'h7FFFFFFF, 32'hFFFFFFFF};
      return {s ? 3'b001 : 3'b010, s, e[6:0], h[23:0], lo};
   endfunction

   task automatic run_op(input logic dbl, input logic [31:0] ahi, alo, bhi, blo);
      @(negedge clk);
      dbl_prec = dbl; a_hi = ahi; a_lo = alo; b_hi = bhi; b_lo = blo; start = 1'b1;
      got_cnt = 0;
      do begin
         @(posedge clk);
         got_cnt++;
         @(negedge clk);
         if (got_cnt == 1) start = 1'b0;
      end while (!done && got_cnt < 400);
      if (!done) chk("R13", "done never rose", 64'h0, 64'h1);
      got_hi = res_hi; got_lo = res_lo; got_cc = cc;
   endtask

   task automatic summary();
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
      end
   end

   initial begin
      logic [131:0] v;
      logic [66:0]  m;
      logic [31:0]  held;
      vtag = '{"R3", "R3", "R10", "R7", "R11", "R7", "R5", "R4",
               "R6", "R9", "R4", "R2", "R2", "R11", "R3"};
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "res_hi", {32'h0, res_hi}, 64'h0);
      chk("R1", "res_lo+cc+done", {28'h0, cc, done, res_lo}, 64'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         v = VEC[i];
         run_op(v[131], v[130:99], v[98:67], v[66:35], v[34:3]);
         m = model(v[131], v[130:99], v[98:67], v[66:35], v[34:3]);
         chk(vtag[i], "res_hi", {32'h0, got_hi}, {32'h0, m[63:32]});
         chk(vtag[i], "res_lo", {32'h0, got_lo}, {32'h0, m[31:0]});
         chk(vtag[i], "cc", {61'h0, got_cc}, {61'h0, v[2:0]});
      end

      // R8: latency for each path
      run_op(1'b0, 32'h41800000, 32'h0, 32'h41800000, 32'h0);
      chk("R8", "single 24-iter latency", 64'(got_cnt), 64'd27);
      run_op(1'b1, 32'h41800000, 32'h0, 32'h41800000, 32'h00000001);
      chk("R8", "double 56-iter latency", 64'(got_cnt), 64'd59);
      run_op(1'b1, 32'h41800000, 32'h00000001, 32'h41800000, 32'h0);
      chk("R8", "double 24-iter latency", 64'(got_cnt), 64'd27);
      run_op(1'b0, 32'h41100000, 32'h0, 32'h41100000, 32'h0);
      chk("R8", "one digit shift latency", 64'(got_cnt), 64'd28);
      run_op(1'b0, 32'h41100000, 32'h0, 32'h00000000, 32'h0);
      chk("R2", "zero short-cut latency", 64'(got_cnt), 64'd2);
      run_op(1'b0, 32'h7F100000, 32'h0, 32'h7F100000, 32'h0);
      chk("R4", "early exit latency", 64'(got_cnt), 64'd2);

      // R13: done is one cycle, outputs hold
      held = res_hi;
      @(negedge clk);
      chk("R13", "done after pulse", {63'h0, done}, 64'h0);
      chk("R13", "res_hi held", {32'h0, res_hi}, {32'h0, held});

      // R12: start and operand changes mid-operation are ignored
      m = model(1'b0, 32'h41200000, 32'h0, 32'h41300000, 32'h0);
      @(negedge clk);
      dbl_prec = 1'b0; a_hi = 32'h41200000; a_lo = '0; b_hi = 32'h41300000; b_lo = '0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      a_hi = 32'hC7700000; b_hi = 32'h7F100000; dbl_prec = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      got_cnt = 0;
      while (!done && got_cnt < 400) begin @(negedge clk); got_cnt++; end
      chk("R12", "res_hi ignores busy start", {32'h0, res_hi}, {32'h0, m[63:32]});
      chk("R12", "cc ignores busy start", {61'h0, cc}, {61'h0, m[66:64]});
      repeat (3) @(negedge clk);
      chk("R12", "no second result", {63'h0, done}, 64'h0);

      summary();
   end
endmodule